// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This unit keeps an interrupt enable register and an interrupt status register for each of five localities and drives one interrupt line shared by all of them. Event pulses arrive from the surrounding logic, each carrying a locality tag and a mask of sources: data available, status valid, locality changed and command ready. An event is recorded only in its own locality. It is recorded only for the sources that locality has enabled, and only while that locality's master enable is on. Recording an event raises the shared line. The line stays up until software clears status.

Software reaches the registers through a simple register bus that uses a locality number and a register select. A write to enable or status takes effect only when it comes from the locality that currently owns the interface. Reads work from any locality. A hard-wired vector register is read-only. The electrical sense of the line follows the polarity field of the owning locality.

Top module: `loc_irq_unit`

## Requirements
- R1: After reset every enable register reads 0x00000008 (polarity field 01 = low level). Every status register reads 0. The level output is 0, and the pin is 1 because the polarity is low.
- R2: An accepted enable write (reg_sel 0) stores the written word ANDed with 0x8000009F. This keeps bit 31 (master enable), bits [4:3] (polarity) and the source bits 7, 2, 1 and 0.
- R3: An event with a valid tag sets the status bits ev_src & enable[7:0] & 0x87 of its locality. This happens only when bit 31 of that locality's enable is 1. Otherwise the status is unchanged.
- R4: An event that records at least one status bit raises irq_level on the next clock edge. The line stays high with no further activity.
- R5: An accepted status write (reg_sel 1) clears the status bits where wdata & 0x87 has ones. Other bits are kept.
- R6: irq_level drops only when all of the following hold: an accepted status write has a supported bit set, it finds its locality's status non-zero, and it leaves that status zero. The line drops even if other localities still hold status. In every other case the line is unchanged.
- R7: Enable and status writes are ignored when reg_loc differs from act_loc, or when act_loc is 5 or above (no owner).
- R8: Events whose ev_loc is 5 or above change no register and do not touch the line.
- R9: reg_sel 2 reads the VECTOR parameter (default 0x00000004) for any locality. Writes to it change nothing.
- R10: irq_pin equals ~irq_level when the polarity field of the owning locality is 01, or when no locality owns the interface. Otherwise irq_pin equals irq_level.
- R11: When an event records status in the same cycle that a status write would clear the line, the line stays high. The resulting status is (old & ~cleared) | recorded.
- R12: reg_sel 3 reads all ones. Reads of enable or status for reg_loc 5 or above also return all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_loc | input | 3 | Locality that owns the interface; 5..7 means none |
| reg_wr | input | 1 | Register write strobe |
| reg_loc | input | 3 | Locality of the register access |
| reg_sel | input | 2 | 0 enable, 1 status, 2 vector, 3 unmapped |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_loc/reg_sel, combinational |
| ev_valid | input | 1 | Event pulse |
| ev_loc | input | 3 | Locality tag of the event |
| ev_src | input | 8 | Source mask: bit0 data avail, bit1 status valid, bit2 locality changed, bit7 command ready |
| irq_level | output | 1 | Registered interrupt level, 1 = asserted |
| irq_pin | output | 1 | Line after polarity inversion |

## Verification
Events are applied with all sources at once and one at a time. The master enable is switched both on and off, so that gating by the source enables can be told apart from gating by the master enable. Status clears are applied as partial clears, full clears, repeated clears of an already empty register, and clears from a non-owning locality. These separate the "status became zero" rule from a plain "write happened" rule. Two localities hold status at the same time, which shows that the line follows only the writer's status. A same-cycle event and clear shows which of the two wins. Polarity is checked with an owner whose field is 01, with owners whose fields are 00 and 11, and with no owner.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;

    localparam int NLOC    = 5;
    localparam int LOC_W   = 3;
    localparam int DW      = 32;
    localparam int SRC_W   = 8;
    localparam int GEN_BIT = 31;

    localparam logic [SRC_W-1:0] SRC_SUP = 8'h87;
    localparam logic [DW-1:0]    EN_KEEP = 32'h8000_009F;
    localparam logic [DW-1:0]    EN_RST  = 32'h0000_0008;
    localparam logic [1:0]       POL_LOW = 2'b01;

    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_ST   = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DW-1:0]    en;
        logic [SRC_W-1:0] st;
    } slot_t;

    typedef struct packed {
        logic level;
    } line_t;

endpackage

// File: rtl/loc_irq_slot.sv
module loc_irq_slot
    import loc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_st,
    input  logic [DW-1:0]    wdata,
    input  logic             ev_hit,
    input  logic [SRC_W-1:0] ev_src,
    output logic [DW-1:0]    en_o,
    output logic [SRC_W-1:0] st_o,
    output logic             set_o,
    output logic             clr_o
);

    slot_t slot_d, slot_q;
    logic [SRC_W-1:0] rec_bits;
    logic [SRC_W-1:0] clr_bits;
    logic [SRC_W-1:0] kept_bits;

    always_comb begin
        slot_d    = slot_q;
        clr_bits  = wr_st ? (wdata[SRC_W-1:0] & SRC_SUP) : '0;
        kept_bits = slot_q.st & ~clr_bits;
        rec_bits  = (ev_hit && slot_q.en[GEN_BIT])
                  ? (ev_src & slot_q.en[SRC_W-1:0] & SRC_SUP) : '0;
        if (wr_en) begin
            slot_d.en = wdata & EN_KEEP;
        end
        slot_d.st = kept_bits | rec_bits;
        set_o     = |rec_bits;
        clr_o     = (|clr_bits) && (|slot_q.st) && (kept_bits == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{en: EN_RST, st: '0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign en_o = slot_q.en;
    assign st_o = slot_q.st;

endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line
    import loc_irq_pkg::*;
#(
    parameter int N = NLOC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [1:0]   pol,
    output logic         level,
    output logic         pin
);

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (|set_vec) begin
            line_d.level = 1'b1;
        end else if (|clr_vec) begin
            line_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{level: 1'b0};
        end else begin
            line_q <= line_d;
        end
    end

    assign level = line_q.level;
    assign pin   = (pol == POL_LOW) ? ~line_q.level : line_q.level;

endmodule

// File: rtl/loc_irq_unit.sv
module loc_irq_unit
    import loc_irq_pkg::*;
#(
    parameter int          NUM_LOC = NLOC,
    parameter logic [31:0] VECTOR  = 32'h0000_0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOC_W-1:0] act_loc,
    input  logic             reg_wr,
    input  logic [LOC_W-1:0] reg_loc,
    input  logic [1:0]       reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             ev_valid,
    input  logic [LOC_W-1:0] ev_loc,
    input  logic [SRC_W-1:0] ev_src,
    output logic             irq_level,
    output logic             irq_pin
);

    localparam logic [LOC_W-1:0] LOC_LIM = LOC_W'(NUM_LOC);

    logic [DW-1:0]    en_arr [NUM_LOC];
    logic [SRC_W-1:0] st_arr [NUM_LOC];
    logic [NUM_LOC-1:0]       set_vec, clr_vec;
    logic [NUM_LOC*DW-1:0]    inte_flat;
    logic [NUM_LOC*SRC_W-1:0] ints_flat;
    logic                     wr_ok;
    logic [1:0]               pol_sel;

    assign wr_ok = reg_wr && (reg_loc == act_loc) && (act_loc < LOC_LIM);

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_slot
        logic hit;
        logic we_en, we_st;
        assign hit   = ev_valid && (ev_loc == LOC_W'(i));
        assign we_en = wr_ok && (reg_loc == LOC_W'(i)) && (reg_sel == SEL_EN);
        assign we_st = wr_ok && (reg_loc == LOC_W'(i)) && (reg_sel == SEL_ST);

        loc_irq_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (we_en),
            .wr_st  (we_st),
            .wdata  (reg_wdata),
            .ev_hit (hit),
            .ev_src (ev_src),
            .en_o   (en_arr[i]),
            .st_o   (st_arr[i]),
            .set_o  (set_vec[i]),
            .clr_o  (clr_vec[i])
        );

        assign inte_flat[i*DW +: DW]       = en_arr[i];
        assign ints_flat[i*SRC_W +: SRC_W] = st_arr[i];
    end

    always_comb begin
        pol_sel = POL_LOW;
        for (int k = 0; k < NUM_LOC; k++) begin
            if (act_loc == LOC_W'(k)) begin
                pol_sel = en_arr[k][4:3];
            end
        end
    end

    loc_irq_line #(.N(NUM_LOC)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pol     (pol_sel),
        .level   (irq_level),
        .pin     (irq_pin)
    );

    always_comb begin
        reg_rdata = '1;
        case (reg_sel)
            SEL_VEC: reg_rdata = VECTOR;
            SEL_EN, SEL_ST: begin
                for (int k = 0; k < NUM_LOC; k++) begin
                    if (reg_loc == LOC_W'(k)) begin
                        reg_rdata = (reg_sel == SEL_EN) ? en_arr[k]
                                  : {{(DW-SRC_W){1'b0}}, st_arr[k]};
                    end
                end
            end
            default: reg_rdata = '1;
        endcase
    end

endmodule

// File: rtl/loc_irq_unit_chk.sv
module loc_irq_unit_chk
    import loc_irq_pkg::*;
#(
    parameter int NUM_LOC = NLOC
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_wr,
    input logic [LOC_W-1:0]         reg_loc,
    input logic [1:0]               reg_sel,
    input logic [LOC_W-1:0]         act_loc,
    input logic                     ev_valid,
    input logic [LOC_W-1:0]         ev_loc,
    input logic [NUM_LOC*DW-1:0]    inte_flat,
    input logic [NUM_LOC*SRC_W-1:0] ints_flat,
    input logic                     irq_level
);

    localparam logic [LOC_W-1:0]         LOC_LIM = LOC_W'(NUM_LOC);
    localparam logic [NUM_LOC*SRC_W-1:0] SUP_ALL = {NUM_LOC{SRC_SUP}};

    // R8: events with an out-of-range tag leave every register alone
    p_bad_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && ev_valid && ev_loc >= LOC_LIM)
        |=> ($stable(ints_flat) && $stable(inte_flat)));

    // R7: writes from a non-owner are dropped
    p_foreign_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_loc != act_loc && !ev_valid)
        |=> ($stable(ints_flat) && $stable(inte_flat)));

    // R9: vector writes change nothing
    p_vec_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_VEC && !ev_valid)
        |=> ($stable(ints_flat) && $stable(inte_flat)));

    // R4: the line only rises after an event
    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> $past(ev_valid));

    // R6: the line only falls after a status write
    p_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_level) |-> $past(reg_wr && reg_sel == SEL_ST));

    // R6: an asserted line always has some recorded status behind it
    p_line_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> (ints_flat != '0));

    // R5: status never holds an unsupported bit
    p_sup_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ints_flat & ~SUP_ALL) == '0);

endmodule

bind loc_irq_unit loc_irq_unit_chk #(.NUM_LOC(NUM_LOC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_loc   (reg_loc),
    .reg_sel   (reg_sel),
    .act_loc   (act_loc),
    .ev_valid  (ev_valid),
    .ev_loc    (ev_loc),
    .inte_flat (inte_flat),
    .ints_flat (ints_flat),
    .irq_level (irq_level)
);

// File: tb/loc_irq_unit_bench.sv
module loc_irq_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  act_loc = 3'd7;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_loc = 3'd0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_loc = 3'd0;
    logic [7:0]  ev_src = 8'h0;
    logic        irq_level, irq_pin;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_en [5];
    logic [7:0]  m_st [5];
    logic        m_lvl;

    always #5 clk = ~clk;

    loc_irq_unit u_loc_irq_unit (
        .clk(clk), .rst_n(rst_n), .act_loc(act_loc),
        .reg_wr(reg_wr), .reg_loc(reg_loc), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_valid(ev_valid), .ev_loc(ev_loc), .ev_src(ev_src),
        .irq_level(irq_level), .irq_pin(irq_pin)
    );

    function automatic logic [31:0] m_read(logic [2:0] loc, logic [1:0] sel);
        if (sel == 2'd2) return 32'h0000_0004;
        if (sel == 2'd3 || loc >= 3'd5) return 32'hFFFF_FFFF;
        if (sel == 2'd0) return m_en[loc];
        return {24'h0, m_st[loc]};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_tick();
        logic [31:0] en_old [5];
        logic        setl, clrl, ok;
        logic [7:0]  cb, nv, rec;
        for (int k = 0; k < 5; k++) en_old[k] = m_en[k];
        setl = 1'b0; clrl = 1'b0;
        ok = reg_wr && (reg_loc == act_loc) && (act_loc < 3'd5);
        if (ok && reg_sel == 2'd0) m_en[reg_loc] = reg_wdata & 32'h8000_009F;
        if (ok && reg_sel == 2'd1) begin
            cb = reg_wdata[7:0] & 8'h87;
            nv = m_st[reg_loc] & ~cb;
            if (cb != 0 && m_st[reg_loc] != 0 && nv == 0) clrl = 1'b1;
            m_st[reg_loc] = nv;
        end
        if (ev_valid && ev_loc < 3'd5 && en_old[ev_loc][31]) begin
            rec = ev_src & en_old[ev_loc][7:0] & 8'h87;
            m_st[ev_loc] = m_st[ev_loc] | rec;
            if (rec != 0) setl = 1'b1;
        end
        if (setl) m_lvl = 1'b1;
        else if (clrl) m_lvl = 1'b0;
    endtask

    task automatic compare(string tag);
        logic [1:0] pol;
        pol = (act_loc < 3'd5) ? m_en[act_loc][4:3] : 2'b01;
        check(tag, "irq_level", {31'h0, irq_level}, {31'h0, m_lvl});
        check(tag, "irq_pin", {31'h0, irq_pin},
              {31'h0, (pol == 2'b01) ? ~m_lvl : m_lvl});
        check(tag, "reg_rdata", reg_rdata, m_read(reg_loc, reg_sel));
    endtask

    task automatic step(string tag, logic wr, logic [2:0] loc, logic [1:0] sel,
                        logic [31:0] wd, logic ev, logic [2:0] el, logic [7:0] es);
        @(negedge clk);
        reg_wr = wr; reg_loc = loc; reg_sel = sel; reg_wdata = wd;
        ev_valid = ev; ev_loc = el; ev_src = es;
        @(posedge clk);
        model_tick();
        #2;
        compare(tag);
    endtask

    task automatic rd(string tag, logic [2:0] loc, logic [1:0] sel);
        step(tag, 1'b0, loc, sel, 32'h0, 1'b0, 3'd0, 8'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) begin m_en[k] = 32'h8; m_st[k] = 8'h0; end
        m_lvl = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd("R1", 3'd0, 2'd0);
        rd("R1", 3'd4, 2'd1);

        // R7: no owner, write ignored
        step("R7", 1'b1, 3'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h0);
        rd("R7", 3'd0, 2'd0);

        // R2: masked enable write
        act_loc = 3'd0;
        step("R2", 1'b1, 3'd0, 2'd0, 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h0);
        rd("R2", 3'd0, 2'd0);

        // R3 R4: recording and line
        step("R3", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd0, 8'h01);
        step("R4", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd0, 8'hFF);
        rd("R4", 3'd0, 2'd1);

        // R5 partial clear, R7 foreign clear
        step("R5", 1'b1, 3'd0, 2'd1, 32'hFFFF_FF01, 1'b0, 3'd0, 8'h0);
        step("R7", 1'b1, 3'd1, 2'd1, 32'h0000_0080, 1'b0, 3'd0, 8'h0);
        rd("R7", 3'd0, 2'd1);
        // R6 full clear drops line
        step("R6", 1'b1, 3'd0, 2'd1, 32'h0000_0086, 1'b0, 3'd0, 8'h0);
        rd("R6", 3'd0, 2'd1);

        // R3: master enable off
        step("R3", 1'b1, 3'd0, 2'd0, 32'h0000_0087, 1'b0, 3'd0, 8'h0);
        step("R3", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd0, 8'h87);
        step("R3", 1'b1, 3'd0, 2'd0, 32'h8000_0009, 1'b0, 3'd0, 8'h0);
        step("R3", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd0, 8'h86);

        // R8: invalid tags dropped
        step("R8", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd5, 8'hFF);
        step("R8", 1'b0, 3'd0, 2'd1, 32'h0, 1'b1, 3'd7, 8'hFF);

        // R9: vector
        step("R9", 1'b1, 3'd0, 2'd2, 32'h1234_5678, 1'b0, 3'd0, 8'h0);
        rd("R9", 3'd3, 2'd2);
        rd("R9", 3'd0, 2'd0);

        // R10: polarity 00 and 11
        act_loc = 3'd2;
        step("R10", 1'b1, 3'd2, 2'd0, 32'h8000_0084, 1'b0, 3'd0, 8'h0);
        step("R10", 1'b0, 3'd2, 2'd1, 32'h0, 1'b1, 3'd2, 8'h04);
        act_loc = 3'd3;
        step("R10", 1'b1, 3'd3, 2'd0, 32'h8000_0098, 1'b0, 3'd0, 8'h0);
        step("R10", 1'b0, 3'd3, 2'd1, 32'h0, 1'b1, 3'd3, 8'h80);

        // R6: writer's own status zero drops line despite loc2 status
        step("R6", 1'b1, 3'd3, 2'd1, 32'h0000_0080, 1'b0, 3'd0, 8'h0);
        rd("R6", 3'd2, 2'd1);
        // R6: clear of empty status does nothing
        step("R6", 1'b1, 3'd3, 2'd1, 32'h0000_0080, 1'b0, 3'd0, 8'h0);
        step("R6", 1'b0, 3'd2, 2'd1, 32'h0, 1'b1, 3'd2, 8'h04);
        step("R6", 1'b1, 3'd3, 2'd1, 32'h0000_0080, 1'b0, 3'd0, 8'h0);

        // R11: same-cycle record beats clear
        step("R11", 1'b0, 3'd3, 2'd1, 32'h0, 1'b1, 3'd3, 8'h80);
        step("R11", 1'b1, 3'd3, 2'd1, 32'h0000_0080, 1'b1, 3'd3, 8'h80);
        step("R11", 1'b1, 3'd3, 2'd1, 32'h0000_0080, 1'b0, 3'd0, 8'h0);

        // R10: no owner uses low polarity
        act_loc = 3'd6;
        rd("R10", 3'd2, 2'd1);

        // R12: unmapped reads
        rd("R12", 3'd0, 2'd3);
        rd("R12", 3'd6, 2'd0);
        rd("R12", 3'd5, 2'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule